// File: doc/BRIEF.md
# Six-Slot Fixed-Latency Wide-Instruction Execution Back End

This block executes one wide instruction word per clock for a statically scheduled machine. Each word holds six slots with a fixed role: two integer slots, two memory slots and two long-latency slots. In this design the long-latency slots do integer multiplication as a stand-in for floating-point work. Every valid slot reads its source registers in the cycle it is presented. It then writes its result into a shared register file after a delay that depends only on the slot's kind. The block has no hazard detection, no stalls and no forwarding. A bundle that reads a register before an earlier write has landed gets the old value, so all scheduling belongs to the compiler.

The memory slots use a small word-addressed local data memory. For every landing edge, the block reports per slot which register was written and with what value. A single combinational observation port reads any register, so the architectural state can be inspected.

Top module: `vliw_exec_core`

## Requirements
- R1: After reset, every register and every data-memory word reads zero and no write-back is reported.
- R2: Slot s uses bits [s*W +: W] of each flat input, where W is the field width. Slots 0-1 are integer, 2-3 are memory and 4-5 are long-latency. Integer ops are 0=ADD (rs1+rs2), 1=SUB (rs1-rs2), 2=ADDI (rs1+imm) and 3=XOR (rs1^rs2). Memory ops are 0=LOAD, 1=STORE and 2/3=no-op. Long ops are 0=MUL (rs1*rs2, low 32 bits), 1=MULI (rs1*imm) and 2/3=no-op. The imm field is 16 bits, sign-extended.
- R3: An integer result is readable by the bundle presented one cycle after issue.
- R4: A load result is readable by the bundle presented three cycles after issue, and not earlier.
- R5: A long-latency result is readable by the bundle presented four cycles after issue, and not earlier.
- R6: All slots of a bundle read their sources before any write of that same bundle lands, with no check between slots.
- R7: The block never stalls. A read of a register whose pending write has not landed returns the previous value.
- R8: When several writes to one register land on the same edge, the highest-numbered slot wins.
- R9: A slot whose valid bit is 0 changes no register and no memory word, and reports no write-back.
- R10: A store commits one cycle after issue. A load in the same bundle as a store to the same word reads the old data.
- R11: When both memory slots store to the same word in one bundle, memory slot 2 (slot 3) wins.
- R12: The memory word address is the low log2(depth) bits of rs1 plus the sign-extended imm, so addresses wrap.
- R13: In the cycle a result becomes readable, wb_vld[s], wb_rd and wb_data report that slot's write. Stores and no-ops never report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 6 | Per-slot valid bit |
| in_op | input | 12 | Per-slot 2-bit operation code |
| in_rd | input | 24 | Per-slot 4-bit destination register |
| in_rs1 | input | 24 | Per-slot 4-bit first source register |
| in_rs2 | input | 24 | Per-slot 4-bit second source register (store data for memory slots) |
| in_imm | input | 96 | Per-slot 16-bit immediate |
| obs_addr | input | 4 | Register to observe |
| obs_data | output | 32 | Current contents of the observed register |
| wb_vld | output | 6 | Per-slot write-back landed on the last edge |
| wb_rd | output | 24 | Per-slot register written |
| wb_data | output | 192 | Per-slot value written |

## Verification
On every cycle, the assertions check the timing of the write-back reports for one slot of each kind. An integer issue must report on the next cycle, a load three cycles after issue and a multiply four cycles after issue, each naming the issuing destination register. Stores and invalid slots must stay silent. Only the bench's scenarios show the values and the ordering. These cover:
- reads just before and just after each latency expires;
- same-bundle reads of registers that the bundle itself writes;
- same-edge collisions between slots;
- store and load ordering, and address wrap-around.

The behavioural reference model checks all of these on every clock, and directed checks confirm each one.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    localparam int NSLOT    = 6;
    localparam int NMEM     = 2;
    localparam int MEM_BASE = 2;
    localparam int OPW      = 2;

    typedef enum logic [1:0] {KIND_INT, KIND_MEM, KIND_LNG} kind_e;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_ADDI = 2'd2,
        OP_XOR  = 2'd3
    } int_op_e;

    typedef enum logic [OPW-1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_MNOP2 = 2'd2,
        OP_MNOP3 = 2'd3
    } mem_op_e;

    typedef enum logic [OPW-1:0] {
        OP_MUL   = 2'd0,
        OP_MULI  = 2'd1,
        OP_LNOP2 = 2'd2,
        OP_LNOP3 = 2'd3
    } lng_op_e;

    function automatic kind_e slot_kind(input int s);
        if (s < MEM_BASE)             return KIND_INT;
        else if (s < MEM_BASE + NMEM) return KIND_MEM;
        else                          return KIND_LNG;
    endfunction

endpackage

// File: rtl/vliw_slot_unit.sv
module vliw_slot_unit
    import vliw_pkg::*;
#(
    parameter kind_e KIND = KIND_INT,
    parameter int    XLEN = 32,
    parameter int    IMMW = 16,
    parameter int    MAW  = 5
) (
    input  logic            vld,
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] ld_data,
    output logic            wr_req,
    output logic            st_req,
    output logic [XLEN-1:0] result,
    output logic [MAW-1:0]  addr
);

    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] addr_full;
    logic            unused_hi;

    assign imm_x     = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign addr_full = src_a + imm_x;
    assign addr      = addr_full[MAW-1:0];
    assign unused_hi = ^addr_full[XLEN-1:MAW];

    always_comb begin
        wr_req = 1'b0;
        st_req = 1'b0;
        result = '0;
        if (KIND == KIND_INT) begin
            wr_req = vld;
            unique case (int_op_e'(op))
                OP_ADD:  result = src_a + src_b;
                OP_SUB:  result = src_a - src_b;
                OP_ADDI: result = src_a + imm_x;
                OP_XOR:  result = src_a ^ src_b;
            endcase
        end else if (KIND == KIND_MEM) begin
            unique case (mem_op_e'(op))
                OP_LOAD: begin
                    wr_req = vld;
                    result = ld_data;
                end
                OP_STORE: st_req = vld;
                default: ;
            endcase
        end else begin
            unique case (lng_op_e'(op))
                OP_MUL: begin
                    wr_req = vld;
                    result = src_a * src_b;
                end
                OP_MULI: begin
                    wr_req = vld;
                    result = src_a * imm_x;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vliw_delay_line.sv
module vliw_delay_line #(
    parameter int DEPTH = 2,
    parameter int W     = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    generate
        if (DEPTH == 0) begin : g_pass
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign out_vld    = in_vld;
            assign out_data   = in_data;
        end else begin : g_pipe
            logic [DEPTH-1:0]        vld_q;
            logic [DEPTH-1:0][W-1:0] dat_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    dat_q <= '0;
                end else begin
                    vld_q[0] <= in_vld;
                    dat_q[0] <= in_data;
                    for (int i = 1; i < DEPTH; i++) begin
                        vld_q[i] <= vld_q[i-1];
                        dat_q[i] <= dat_q[i-1];
                    end
                end
            end

            assign out_vld  = vld_q[DEPTH-1];
            assign out_data = dat_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    parameter int NWP  = 6,
    parameter int NRP  = 13,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NWP-1:0]      we,
    input  logic [NWP*AW-1:0]   waddr,
    input  logic [NWP*XLEN-1:0] wdata,
    input  logic [NRP*AW-1:0]   raddr,
    output logic [NRP*XLEN-1:0] rdata
);

    logic [XLEN-1:0] regs [NREG];

    // later ports overwrite earlier ones: higher index has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs[r] <= '0;
        end else begin
            for (int p = 0; p < NWP; p++) begin
                if (we[p]) regs[waddr[p*AW +: AW]] <= wdata[p*XLEN +: XLEN];
            end
        end
    end

    generate
        for (genvar rp = 0; rp < NRP; rp++) begin : g_rd
            assign rdata[rp*XLEN +: XLEN] = regs[raddr[rp*AW +: AW]];
        end
    endgenerate

endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem #(
    parameter int WORDS = 32,
    parameter int XLEN  = 32,
    parameter int NP    = 2,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NP-1:0]      we,
    input  logic [NP*AW-1:0]   waddr,
    input  logic [NP*XLEN-1:0] wdata,
    input  logic [NP*AW-1:0]   raddr,
    output logic [NP*XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (we[p]) mem[waddr[p*AW +: AW]] <= wdata[p*XLEN +: XLEN];
            end
        end
    end

    generate
        for (genvar rp = 0; rp < NP; rp++) begin : g_rd
            assign rdata[rp*XLEN +: XLEN] = mem[raddr[rp*AW +: AW]];
        end
    endgenerate

endmodule

// File: rtl/vliw_exec_core.sv
module vliw_exec_core
    import vliw_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREG       = 16,
    parameter int DMEM_WORDS = 32,
    parameter int IMMW       = 16,
    parameter int LAT_INT    = 1,
    parameter int LAT_MEM    = 3,
    parameter int LAT_LNG    = 4,
    localparam int RAW       = $clog2(NREG),
    localparam int MAW       = $clog2(DMEM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      in_vld,
    input  logic [NSLOT*OPW-1:0]  in_op,
    input  logic [NSLOT*RAW-1:0]  in_rd,
    input  logic [NSLOT*RAW-1:0]  in_rs1,
    input  logic [NSLOT*RAW-1:0]  in_rs2,
    input  logic [NSLOT*IMMW-1:0] in_imm,
    input  logic [RAW-1:0]        obs_addr,
    output logic [XLEN-1:0]       obs_data,
    output logic [NSLOT-1:0]      wb_vld,
    output logic [NSLOT*RAW-1:0]  wb_rd,
    output logic [NSLOT*XLEN-1:0] wb_data
);

    localparam int NRD = 2*NSLOT + 1;
    localparam int PW  = RAW + XLEN;

    logic [NRD*RAW-1:0]   rf_raddr;
    logic [NRD*XLEN-1:0]  rf_rdata;
    logic [NSLOT-1:0]     tail_vld;
    logic [NSLOT*RAW-1:0] tail_rd;
    logic [NSLOT*XLEN-1:0] tail_data;

    logic [NMEM-1:0]      dm_we;
    logic [NMEM*MAW-1:0]  dm_waddr;
    logic [NMEM*XLEN-1:0] dm_wdata;
    logic [NMEM*MAW-1:0]  dm_raddr;
    logic [NMEM*XLEN-1:0] dm_rdata;

    logic [XLEN-1:0] s_a      [NSLOT];
    logic [XLEN-1:0] s_b      [NSLOT];
    logic [XLEN-1:0] s_ld     [NSLOT];
    logic [XLEN-1:0] s_res    [NSLOT];
    logic [MAW-1:0]  s_addr   [NSLOT];
    logic            s_wr     [NSLOT];
    logic            s_st     [NSLOT];

    assign rf_raddr[2*NSLOT*RAW +: RAW] = obs_addr;
    assign obs_data = rf_rdata[2*NSLOT*XLEN +: XLEN];

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            localparam kind_e K   = slot_kind(s);
            localparam int    LAT = (K == KIND_INT) ? LAT_INT :
                                    (K == KIND_MEM) ? LAT_MEM : LAT_LNG;

            assign rf_raddr[(2*s)*RAW   +: RAW] = in_rs1[s*RAW +: RAW];
            assign rf_raddr[(2*s+1)*RAW +: RAW] = in_rs2[s*RAW +: RAW];
            assign s_a[s] = rf_rdata[(2*s)*XLEN   +: XLEN];
            assign s_b[s] = rf_rdata[(2*s+1)*XLEN +: XLEN];

            vliw_slot_unit #(
                .KIND (K),
                .XLEN (XLEN),
                .IMMW (IMMW),
                .MAW  (MAW)
            ) u_unit (
                .vld     (in_vld[s]),
                .op      (in_op[s*OPW +: OPW]),
                .src_a   (s_a[s]),
                .src_b   (s_b[s]),
                .imm     (in_imm[s*IMMW +: IMMW]),
                .ld_data (s_ld[s]),
                .wr_req  (s_wr[s]),
                .st_req  (s_st[s]),
                .result  (s_res[s]),
                .addr    (s_addr[s])
            );

            if (K == KIND_MEM) begin : g_mem
                localparam int M = s - MEM_BASE;
                assign dm_raddr[M*MAW +: MAW]   = s_addr[s];
                assign dm_waddr[M*MAW +: MAW]   = s_addr[s];
                assign dm_we[M]                 = s_st[s];
                assign dm_wdata[M*XLEN +: XLEN] = s_b[s];
                assign s_ld[s] = dm_rdata[M*XLEN +: XLEN];
            end else begin : g_nomem
                assign s_ld[s] = '0;
            end

            vliw_delay_line #(
                .DEPTH (LAT - 1),
                .W     (PW)
            ) u_delay (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (s_wr[s]),
                .in_data  ({in_rd[s*RAW +: RAW], s_res[s]}),
                .out_vld  (tail_vld[s]),
                .out_data ({tail_rd[s*RAW +: RAW], tail_data[s*XLEN +: XLEN]})
            );
        end
    endgenerate

    vliw_regfile #(
        .NREG (NREG),
        .XLEN (XLEN),
        .NWP  (NSLOT),
        .NRP  (NRD)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tail_vld),
        .waddr (tail_rd),
        .wdata (tail_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    vliw_dmem #(
        .WORDS (DMEM_WORDS),
        .XLEN  (XLEN),
        .NP    (NMEM)
    ) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_vld  <= '0;
            wb_rd   <= '0;
            wb_data <= '0;
        end else begin
            wb_vld  <= tail_vld;
            wb_rd   <= tail_rd;
            wb_data <= tail_data;
        end
    end

endmodule

// File: rtl/vliw_exec_checker.sv
module vliw_exec_checker
    import vliw_pkg::*;
#(
    parameter int RAW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NSLOT-1:0]     in_vld,
    input logic [NSLOT*OPW-1:0] in_op,
    input logic [NSLOT*RAW-1:0] in_rd,
    input logic [NSLOT-1:0]     wb_vld,
    input logic [NSLOT*RAW-1:0] wb_rd
);

    // R3 / R13: integer slot 1 reports its write on the next cycle
    p_int_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld[0] |=> (wb_vld[0] && wb_rd[0 +: RAW] == $past(in_rd[0 +: RAW])));

    // R9: an invalid integer slot reports nothing
    p_int_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld[0] |=> !wb_vld[0]);

    // R4 / R13: a load on memory slot 1 reports three cycles after issue
    p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[2] && in_op[2*OPW +: OPW] == 2'd0) |=> ##2
        (wb_vld[2] && wb_rd[2*RAW +: RAW] == $past(in_rd[2*RAW +: RAW], 3)));

    // R13: a store never reports a register write
    p_store_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[2] && in_op[2*OPW +: OPW] == 2'd1) |=> ##2 !wb_vld[2]);

    // R5 / R13: a multiply on long slot 1 reports four cycles after issue
    p_long_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[4] && in_op[4*OPW +: OPW] == 2'd0) |=> ##3
        (wb_vld[4] && wb_rd[4*RAW +: RAW] == $past(in_rd[4*RAW +: RAW], 4)));

endmodule

bind vliw_exec_core vliw_exec_checker #(.RAW(RAW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .in_op  (in_op),
    .in_rd  (in_rd),
    .wb_vld (wb_vld),
    .wb_rd  (wb_rd)
);

// File: tb/vliw_exec_core_bench.sv
module vliw_exec_core_bench;

    localparam int NS = 6;
    localparam int NR = 16;
    localparam int NW = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   in_vld = '0;
    logic [11:0]  in_op = '0;
    logic [23:0]  in_rd = '0;
    logic [23:0]  in_rs1 = '0;
    logic [23:0]  in_rs2 = '0;
    logic [95:0]  in_imm = '0;
    logic [3:0]   obs_addr = '0;
    logic [31:0]  obs_data;
    logic [5:0]   wb_vld;
    logic [23:0]  wb_rd;
    logic [191:0] wb_data;

    vliw_exec_core u_vliw_exec_core (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
        .obs_addr(obs_addr), .obs_data(obs_data),
        .wb_vld(wb_vld), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    always #5ns clk = ~clk;

    typedef struct {
        int          due;
        int          slot;
        logic [3:0]  rd;
        logic [31:0] data;
    } pend_t;

    int          checks = 0;
    int          failures = 0;
    int          edge_n = 0;
    bit          finished = 0;
    logic [31:0] ref_rf [NR];
    logic [31:0] ref_mem [NW];
    pend_t       pq [$];
    logic        exp_vld [NS];
    logic [3:0]  exp_rd [NS];
    logic [31:0] exp_dat [NS];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string slot_tag(input int s);
        if (s < 2) return "R3";
        if (s < 4) return "R4";
        return "R5";
    endfunction

    task automatic clear_bundle();
        in_vld = '0; in_op = '0; in_rd = '0;
        in_rs1 = '0; in_rs2 = '0; in_imm = '0;
    endtask

    task automatic set_slot(input int s, input logic [1:0] op, input logic [3:0] rd,
                            input logic [3:0] rs1, input logic [3:0] rs2, input logic [15:0] imm);
        in_vld[s] = 1'b1;
        in_op[s*2 +: 2] = op;
        in_rd[s*4 +: 4] = rd;
        in_rs1[s*4 +: 4] = rs1;
        in_rs2[s*4 +: 4] = rs2;
        in_imm[s*16 +: 16] = imm;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        obs_addr = a;
        #1ns;
        v = obs_data;
    endtask

    // one bundle: model issue, clock edge, model landing, compare
    task automatic tick();
        logic [31:0] st_data [2];
        logic [4:0]  st_addr [2];
        logic        st_en [2];
        pend_t       keep [$];
        obs_addr = 4'(edge_n % NR);
        for (int s = 0; s < NS; s++) begin
            logic [31:0] a, b, ix, r;
            logic [4:0]  ad;
            a  = ref_rf[in_rs1[s*4 +: 4]];
            b  = ref_rf[in_rs2[s*4 +: 4]];
            ix = {{16{in_imm[s*16+15]}}, in_imm[s*16 +: 16]};
            ad = 5'(a + ix);
            if (s >= 2 && s < 4) st_en[s-2] = 1'b0;
            if (in_vld[s]) begin
                if (s < 2) begin
                    case (in_op[s*2 +: 2])
                        2'd0: r = a + b;
                        2'd1: r = a - b;
                        2'd2: r = a + ix;
                        default: r = a ^ b;
                    endcase
                    pq.push_back('{edge_n, s, in_rd[s*4 +: 4], r});
                end else if (s < 4) begin
                    if (in_op[s*2 +: 2] == 2'd0)
                        pq.push_back('{edge_n + 2, s, in_rd[s*4 +: 4], ref_mem[ad]});
                    else if (in_op[s*2 +: 2] == 2'd1) begin
                        st_en[s-2] = 1'b1; st_addr[s-2] = ad; st_data[s-2] = b;
                    end
                end else begin
                    if (in_op[s*2 +: 2] == 2'd0)
                        pq.push_back('{edge_n + 3, s, in_rd[s*4 +: 4], a * b});
                    else if (in_op[s*2 +: 2] == 2'd1)
                        pq.push_back('{edge_n + 3, s, in_rd[s*4 +: 4], a * ix});
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) if (st_en[m]) ref_mem[st_addr[m]] = st_data[m];
        for (int s = 0; s < NS; s++) begin
            exp_vld[s] = 1'b0; exp_rd[s] = '0; exp_dat[s] = '0;
        end
        for (int s = 0; s < NS; s++) begin
            foreach (pq[i]) begin
                if (pq[i].due == edge_n && pq[i].slot == s) begin
                    ref_rf[pq[i].rd] = pq[i].data;
                    exp_vld[s] = 1'b1; exp_rd[s] = pq[i].rd; exp_dat[s] = pq[i].data;
                end
            end
        end
        foreach (pq[i]) if (pq[i].due != edge_n) keep.push_back(pq[i]);
        pq = keep;
        for (int s = 0; s < NS; s++) begin
            chk({slot_tag(s), " R13 wb_vld"}, 32'(wb_vld[s]), 32'(exp_vld[s]));
            if (exp_vld[s]) begin
                chk({slot_tag(s), " wb_rd"}, 32'(wb_rd[s*4 +: 4]), 32'(exp_rd[s]));
                chk({slot_tag(s), " wb_data"}, wb_data[s*32 +: 32], exp_dat[s]);
            end
        end
        chk("R7 register contents", obs_data, ref_rf[obs_addr]);
        edge_n++;
        clear_bundle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        for (int r = 0; r < NR; r++) ref_rf[r] = '0;
        for (int w = 0; w < NW; w++) ref_mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 wb_vld after reset", 32'(wb_vld), 32'd0);
        for (int r = 0; r < NR; r++) begin
            peek(4'(r), v);
            chk("R1 register zero", v, 32'd0);
        end

        // R6: slot 1 reads r1 while slot 0 writes it
        set_slot(0, 2'd2, 4'd1, 4'd0, 4'd0, 16'd7);
        set_slot(1, 2'd0, 4'd2, 4'd1, 4'd0, 16'd0);
        tick();
        chk("R6 same-bundle read old", wb_data[32 +: 32], 32'd0);
        // R3: next bundle sees integer result
        set_slot(0, 2'd0, 4'd3, 4'd1, 4'd1, 16'd0);
        tick();
        chk("R3 int visible next cycle", wb_data[0 +: 32], 32'd14);
        // R5 / R7: multiply r4 = r1*3
        set_slot(4, 2'd1, 4'd4, 4'd1, 4'd0, 16'd3);
        tick();
        set_slot(0, 2'd2, 4'd5, 4'd4, 4'd0, 16'd0);
        tick();
        chk("R7 read at +1 old", wb_data[0 +: 32], 32'd0);
        set_slot(0, 2'd2, 4'd6, 4'd4, 4'd0, 16'd0);
        tick();
        chk("R7 read at +2 old", wb_data[0 +: 32], 32'd0);
        chk("R5 not landed at +2", 32'(wb_vld[4]), 32'd0);
        set_slot(0, 2'd2, 4'd7, 4'd4, 4'd0, 16'd0);
        tick();
        chk("R5 read at +3 old", wb_data[0 +: 32], 32'd0);
        chk("R5 landing report", wb_data[128 +: 32], 32'd21);
        set_slot(0, 2'd2, 4'd8, 4'd4, 4'd0, 16'd0);
        tick();
        chk("R5 read at +4 new", wb_data[0 +: 32], 32'd21);

        // R10: store and load to word 5 in one bundle
        set_slot(2, 2'd1, 4'd0, 4'd0, 4'd1, 16'd5);
        set_slot(3, 2'd0, 4'd9, 4'd0, 4'd0, 16'd5);
        tick();
        set_slot(2, 2'd0, 4'd10, 4'd0, 4'd0, 16'd5);
        tick();
        tick();
        chk("R10 same-bundle load old", wb_data[96 +: 32], 32'd0);
        // R4: r10 readable 3 cycles after its load
        set_slot(0, 2'd2, 4'd11, 4'd10, 4'd0, 16'd0);
        tick();
        chk("R10 store visible next cycle", wb_data[64 +: 32], 32'd7);
        chk("R4 read at +2 old", wb_data[0 +: 32], 32'd0);
        set_slot(1, 2'd2, 4'd12, 4'd10, 4'd0, 16'd0);
        tick();
        chk("R4 read at +3 new", wb_data[32 +: 32], 32'd7);

        // R8: three writes to r13 land on one edge
        set_slot(4, 2'd1, 4'd13, 4'd1, 4'd0, 16'd1);
        tick();
        tick();
        tick();
        set_slot(0, 2'd2, 4'd13, 4'd0, 4'd0, 16'd100);
        set_slot(1, 2'd2, 4'd13, 4'd0, 4'd0, 16'd200);
        tick();
        peek(4'd13, v);
        chk("R8 long slot wins collision", v, 32'd7);
        set_slot(0, 2'd2, 4'd14, 4'd0, 4'd0, 16'd1);
        set_slot(1, 2'd2, 4'd14, 4'd0, 4'd0, 16'd2);
        tick();
        peek(4'd14, v);
        chk("R8 int slot 2 wins", v, 32'd2);

        // R9: invalid slots
        set_slot(0, 2'd2, 4'd1, 4'd0, 4'd0, 16'd999);
        set_slot(2, 2'd1, 4'd0, 4'd0, 4'd14, 16'd5);
        in_vld = '0;
        tick();
        chk("R9 invalid no report", 32'(wb_vld[0]), 32'd0);
        peek(4'd1, v);
        chk("R9 register untouched", v, 32'd7);
        set_slot(3, 2'd0, 4'd15, 4'd0, 4'd0, 16'd5);
        tick(); tick(); tick();
        peek(4'd15, v);
        chk("R9 memory untouched", v, 32'd7);

        // R11: both memory slots store to word 9
        set_slot(2, 2'd1, 4'd0, 4'd0, 4'd1, 16'd9);
        set_slot(3, 2'd1, 4'd0, 4'd0, 4'd14, 16'd9);
        tick();
        set_slot(2, 2'd0, 4'd15, 4'd0, 4'd0, 16'd9);
        tick(); tick(); tick();
        peek(4'd15, v);
        chk("R11 memory slot 2 wins", v, 32'd2);

        // R12: address wraps, negative immediate
        set_slot(3, 2'd1, 4'd0, 4'd0, 4'd1, 16'd35);
        tick();
        set_slot(2, 2'd0, 4'd15, 4'd0, 4'd0, 16'd3);
        set_slot(3, 2'd0, 4'd11, 4'd1, 4'd0, 16'hFFFC);
        tick(); tick(); tick();
        peek(4'd15, v);
        chk("R12 wrapped store address", v, 32'd7);
        peek(4'd11, v);
        chk("R12 negative offset", v, 32'd7);

        // R2: remaining op codes and no-ops
        set_slot(0, 2'd1, 4'd2, 4'd1, 4'd14, 16'd0);
        set_slot(1, 2'd3, 4'd3, 4'd1, 4'd14, 16'd0);
        set_slot(2, 2'd2, 4'd6, 4'd1, 4'd1, 16'd0);
        set_slot(4, 2'd2, 4'd5, 4'd1, 4'd1, 16'd0);
        set_slot(5, 2'd0, 4'd4, 4'd1, 4'd14, 16'd0);
        tick();
        chk("R2 SUB", wb_data[0 +: 32], 32'd5);
        chk("R2 XOR", wb_data[32 +: 32], 32'd5);
        tick(); tick();
        chk("R2 memory no-op silent", 32'(wb_vld[2]), 32'd0);
        tick();
        chk("R2 MUL", wb_data[160 +: 32], 32'd14);
        chk("R2 long no-op silent", 32'(wb_vld[4]), 32'd0);

        // mixed traffic against the reference model
        for (int k = 0; k < 400; k++) begin
            for (int s = 0; s < NS; s++) begin
                if ($urandom_range(0, 9) < 8)
                    set_slot(s, 2'($urandom), 4'($urandom), 4'($urandom),
                             4'($urandom), 16'($urandom_range(0, 80)));
            end
            tick();
        end
        repeat (6) tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule